// File: doc/BRIEF.md
# Radio Power Mode Controller

This block turns four static control levels into the power enables of a radio front end. The four levels are oscillator enable, receive-off, transmit select and synthesizer enable. The enables cover the oscillator chain, the transmit preamplifier, the receive local-oscillator buffer and the PLL group. The PLL group is the two dividers, the phase detector and the charge pump. The block also drives the RF path select, which always follows transmit select, whichever amplifier happens to be powered.

Two settling timers model the start-up times of the analog parts. The oscillator needs about 30 µs and the transmit preamplifier about 10 µs. Each timer is sized from a cycles-per-microsecond parameter. Each raises a ready flag once its supply has been held on for the full interval. The flag drops in the same cycle the supply is removed, and the timer starts again from zero on the next enable.

Two output-valid flags combine oscillator readiness, amplifier readiness and the path select. Baseband logic uses them to tell when a usable transmit or local-oscillator signal exists.

Top module: `radio_pwr_ctrl`

## Requirements
- R1: While oscillator enable is low, the oscillator chain enable, the preamplifier enable and the LO buffer enable are all low. While it is high, the oscillator chain enable is high.
- R2: The preamplifier enable is high exactly when oscillator enable and receive-off are both high.
- R3: The LO buffer enable is high exactly when oscillator enable is high and receive-off is low.
- R4: The path select output is 1 (transmit amplifier) when transmit select is high and 0 (LO buffer) when it is low. This holds for every value of the other controls.
- R5: The PLL enable is high exactly when synthesizer enable is high, independent of the other controls.
- R6: The oscillator ready flag rises on the OSC_US*CYC_PER_US-th rising clock edge at which the oscillator chain enable is sampled high without a break, and not before.
- R7: The preamplifier ready flag rises on the AMP_US*CYC_PER_US-th rising clock edge at which the preamplifier enable is sampled high without a break, and not before.
- R8: A ready flag goes low in the same cycle its enable goes low. The next enable restarts its full settling interval from zero.
- R9: The transmit-valid flag is high exactly when the oscillator is ready, the preamplifier is ready and the path select is 1. The LO-valid flag is high exactly when the oscillator is ready, the LO buffer is enabled and the path select is 0.
- R10: A synchronous active-high reset clears both timers, so both ready flags and both valid flags are low after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en_i | input | 1 | Oscillator enable control |
| rx_off_i | input | 1 | Receive-off control |
| tx_sel_i | input | 1 | Transmit select control |
| syn_en_i | input | 1 | Synthesizer enable control |
| chain_pwr_o | output | 1 | Oscillator, buffer, doubler and switch enable |
| txamp_pwr_o | output | 1 | Transmit preamplifier enable |
| lobuf_pwr_o | output | 1 | Receive LO buffer enable |
| pll_pwr_o | output | 1 | PLL group enable |
| path_tx_o | output | 1 | RF path select, 1 = transmit amplifier |
| osc_rdy_o | output | 1 | Oscillator settled |
| txamp_rdy_o | output | 1 | Preamplifier settled |
| tx_valid_o | output | 1 | Usable transmit signal |
| lo_valid_o | output | 1 | Usable LO signal |

## Verification
The assertions assume that the four controls are synchronous to the clock and change only between edges. The ready checks count uninterrupted enabled edges from the first edge after reset, so they also assume that reset is applied before any settling interval is measured.

The stimulus drives every control change on the falling edge. It applies reset at the start and once more while the flags are high, and the timing checks are sampled on the falling edge after the counted rising edge.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

    typedef struct packed {
        logic osc_en;
        logic rx_off;
        logic tx_sel;
        logic syn_en;
    } ctrl_t;

    typedef struct packed {
        logic chain;
        logic txamp;
        logic lobuf;
        logic pll;
        logic path_tx;
    } pwr_t;

    typedef enum int unsigned {
        TMR_OSC = 0,
        TMR_AMP = 1
    } tmr_idx_e;

    localparam int unsigned NUM_TMR = 2;

    function automatic int unsigned settle_cycles(input int unsigned us,
                                                  input int unsigned cyc_per_us);
        return (us * cyc_per_us < 1) ? 1 : us * cyc_per_us;
    endfunction

    function automatic pwr_t decode_mode(input ctrl_t c);
        pwr_t p;
        p.chain   = c.osc_en;
        p.txamp   = c.osc_en & c.rx_off;
        p.lobuf   = c.osc_en & ~c.rx_off;
        p.pll     = c.syn_en;
        p.path_tx = c.tx_sel;
        return p;
    endfunction

endpackage

// File: rtl/rpc_decode.sv
module rpc_decode
    import rpc_pkg::*;
(
    input  ctrl_t ctrl_i,
    output pwr_t  pwr_o
);
    always_comb begin
        pwr_o = decode_mode(ctrl_i);
    end
endmodule

// File: rtl/rpc_settle_timer.sv
module rpc_settle_timer #(
    parameter int unsigned LIMIT = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    output logic rdy_o
);
    localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;
    logic          rdy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            rdy_q <= 1'b0;
        end else if (!en_i) begin
            cnt_q <= '0;
            rdy_q <= 1'b0;
        end else if (!rdy_q) begin
            if (cnt_q == LAST) begin
                rdy_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // flag falls in the same cycle the supply is removed
    assign rdy_o = rdy_q & en_i;
endmodule

// File: rtl/rpc_path_qual.sv
module rpc_path_qual
    import rpc_pkg::*;
(
    input  pwr_t pwr_i,
    input  logic osc_rdy_i,
    input  logic amp_rdy_i,
    output logic tx_valid_o,
    output logic lo_valid_o
);
    always_comb begin
        tx_valid_o = osc_rdy_i & amp_rdy_i & pwr_i.path_tx;
        lo_valid_o = osc_rdy_i & pwr_i.lobuf & ~pwr_i.path_tx;
    end
endmodule

// File: rtl/radio_pwr_ctrl.sv
module radio_pwr_ctrl
    import rpc_pkg::*;
#(
    parameter int unsigned CYC_PER_US = 4,
    parameter int unsigned OSC_US     = 30,
    parameter int unsigned AMP_US     = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_en_i,
    input  logic rx_off_i,
    input  logic tx_sel_i,
    input  logic syn_en_i,
    output logic chain_pwr_o,
    output logic txamp_pwr_o,
    output logic lobuf_pwr_o,
    output logic pll_pwr_o,
    output logic path_tx_o,
    output logic osc_rdy_o,
    output logic txamp_rdy_o,
    output logic tx_valid_o,
    output logic lo_valid_o
);
    localparam int unsigned OSC_CYC = settle_cycles(OSC_US, CYC_PER_US);
    localparam int unsigned AMP_CYC = settle_cycles(AMP_US, CYC_PER_US);

    ctrl_t ctrl;
    pwr_t  pwr;
    logic [NUM_TMR-1:0] tmr_en;
    logic [NUM_TMR-1:0] tmr_rdy;

    assign ctrl = '{osc_en: osc_en_i, rx_off: rx_off_i,
                    tx_sel: tx_sel_i, syn_en: syn_en_i};

    rpc_decode u_dec (
        .ctrl_i (ctrl),
        .pwr_o  (pwr)
    );

    assign tmr_en[TMR_OSC] = pwr.chain;
    assign tmr_en[TMR_AMP] = pwr.txamp;

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        localparam int unsigned LIM = (g == TMR_OSC) ? OSC_CYC : AMP_CYC;
        rpc_settle_timer #(.LIMIT(LIM)) u_tmr (
            .clk   (clk),
            .rst   (rst),
            .en_i  (tmr_en[g]),
            .rdy_o (tmr_rdy[g])
        );
    end

    rpc_path_qual u_qual (
        .pwr_i      (pwr),
        .osc_rdy_i  (tmr_rdy[TMR_OSC]),
        .amp_rdy_i  (tmr_rdy[TMR_AMP]),
        .tx_valid_o (tx_valid_o),
        .lo_valid_o (lo_valid_o)
    );

    assign chain_pwr_o = pwr.chain;
    assign txamp_pwr_o = pwr.txamp;
    assign lobuf_pwr_o = pwr.lobuf;
    assign pll_pwr_o   = pwr.pll;
    assign path_tx_o   = pwr.path_tx;
    assign osc_rdy_o   = tmr_rdy[TMR_OSC];
    assign txamp_rdy_o = tmr_rdy[TMR_AMP];
endmodule

// File: rtl/rpc_chk.sv
module rpc_chk #(
    parameter int unsigned OSC_LIM = 120,
    parameter int unsigned AMP_LIM = 40
) (
    input logic clk,
    input logic rst,
    input logic osc_en_i,
    input logic rx_off_i,
    input logic tx_sel_i,
    input logic syn_en_i,
    input logic chain_pwr_o,
    input logic txamp_pwr_o,
    input logic lobuf_pwr_o,
    input logic pll_pwr_o,
    input logic path_tx_o,
    input logic osc_rdy_o,
    input logic txamp_rdy_o,
    input logic tx_valid_o,
    input logic lo_valid_o
);
    localparam int unsigned OW = $clog2(OSC_LIM + 1);
    localparam int unsigned AW = $clog2(AMP_LIM + 1);

    logic [OW-1:0] osc_run;
    logic [AW-1:0] amp_run;

    always_ff @(posedge clk) begin
        if (rst || !chain_pwr_o) osc_run <= '0;
        else if (osc_run != OW'(OSC_LIM)) osc_run <= osc_run + 1'b1;
        if (rst || !txamp_pwr_o) amp_run <= '0;
        else if (amp_run != AW'(AMP_LIM)) amp_run <= amp_run + 1'b1;
    end

    // R1
    chain_off_chk: assert property (@(posedge clk) disable iff (rst)
        !osc_en_i |-> (!chain_pwr_o && !txamp_pwr_o && !lobuf_pwr_o));

    // R2
    amp_sel_chk: assert property (@(posedge clk) disable iff (rst)
        txamp_pwr_o |-> (chain_pwr_o && rx_off_i && !lobuf_pwr_o));

    // R3
    lobuf_sel_chk: assert property (@(posedge clk) disable iff (rst)
        lobuf_pwr_o |-> (chain_pwr_o && !rx_off_i && !txamp_pwr_o));

    // R4
    path_follow_chk: assert property (@(posedge clk) disable iff (rst)
        path_tx_o == tx_sel_i);

    // R5
    pll_follow_chk: assert property (@(posedge clk) disable iff (rst)
        pll_pwr_o == syn_en_i);

    // R6
    osc_settle_chk: assert property (@(posedge clk) disable iff (rst)
        osc_rdy_o |-> (osc_run == OW'(OSC_LIM)));

    // R7
    amp_settle_chk: assert property (@(posedge clk) disable iff (rst)
        txamp_rdy_o |-> (amp_run == AW'(AMP_LIM)));

    // R8
    rdy_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (!chain_pwr_o |-> !osc_rdy_o) and (!txamp_pwr_o |-> !txamp_rdy_o));

    // R9
    valid_qual_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid_o |-> (path_tx_o && osc_rdy_o && txamp_rdy_o)) and
        (lo_valid_o |-> (!path_tx_o && osc_rdy_o && lobuf_pwr_o)));
endmodule

bind radio_pwr_ctrl rpc_chk #(
    .OSC_LIM (OSC_CYC),
    .AMP_LIM (AMP_CYC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .osc_en_i    (osc_en_i),
    .rx_off_i    (rx_off_i),
    .tx_sel_i    (tx_sel_i),
    .syn_en_i    (syn_en_i),
    .chain_pwr_o (chain_pwr_o),
    .txamp_pwr_o (txamp_pwr_o),
    .lobuf_pwr_o (lobuf_pwr_o),
    .pll_pwr_o   (pll_pwr_o),
    .path_tx_o   (path_tx_o),
    .osc_rdy_o   (osc_rdy_o),
    .txamp_rdy_o (txamp_rdy_o),
    .tx_valid_o  (tx_valid_o),
    .lo_valid_o  (lo_valid_o)
);

// File: tb/sim_radio_pwr_ctrl.sv
module sim_radio_pwr_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int CPU  = 4;
    localparam int OSCN = 30 * CPU;
    localparam int AMPN = 10 * CPU;

    // index bits {osc_en, rx_off, tx_sel, syn_en}
    // -> expected {chain, txamp, lobuf, pll, path_tx}
    localparam logic [4:0] EXP [16] = '{
        5'b00000, 5'b00010, 5'b00001, 5'b00011,
        5'b00000, 5'b00010, 5'b00001, 5'b00011,
        5'b10100, 5'b10110, 5'b10101, 5'b10111,
        5'b11000, 5'b11010, 5'b11001, 5'b11011
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic osc_en = 1'b0, rx_off = 1'b0, tx_sel = 1'b0, syn_en = 1'b0;
    logic chain_pwr, txamp_pwr, lobuf_pwr, pll_pwr, path_tx;
    logic osc_rdy, txamp_rdy, tx_valid, lo_valid;
    int   n_chk = 0;
    int   n_err = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    radio_pwr_ctrl #(.CYC_PER_US(CPU), .OSC_US(30), .AMP_US(10)) u0 (
        .clk(clk), .rst(rst),
        .osc_en_i(osc_en), .rx_off_i(rx_off), .tx_sel_i(tx_sel), .syn_en_i(syn_en),
        .chain_pwr_o(chain_pwr), .txamp_pwr_o(txamp_pwr), .lobuf_pwr_o(lobuf_pwr),
        .pll_pwr_o(pll_pwr), .path_tx_o(path_tx),
        .osc_rdy_o(osc_rdy), .txamp_rdy_o(txamp_rdy),
        .tx_valid_o(tx_valid), .lo_valid_o(lo_valid)
    );

    task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        // R10: reset held with oscillator enabled for longer than settling
        osc_en = 1'b1; rx_off = 1'b1; tx_sel = 1'b1;
        edges(OSCN + 5);
        chk("R10 reset flags", {osc_rdy, txamp_rdy, tx_valid, lo_valid, 1'b0}, 5'b0);
        osc_en = 1'b0; rx_off = 1'b0; tx_sel = 1'b0;
        rst = 1'b0;
        edges(2);

        // R1 R2 R3 R4 R5: decode table
        for (int i = 0; i < 16; i++) begin
            {osc_en, rx_off, tx_sel, syn_en} = 4'(i);
            #1;
            chk("R1/R2/R3/R4/R5 decode",
                {chain_pwr, txamp_pwr, lobuf_pwr, pll_pwr, path_tx}, EXP[i]);
            osc_en = 1'b0;
            edges(1);
        end
        {osc_en, rx_off, tx_sel, syn_en} = 4'b0000;
        edges(2);

        // R6 R7: enable oscillator and preamplifier together, transmit path
        osc_en = 1'b1; rx_off = 1'b1; tx_sel = 1'b1;
        edges(AMPN - 1);
        chk("R7 amp not yet", {4'b0, txamp_rdy}, 5'b0);
        edges(1);
        chk("R7 amp ready", {4'b0, txamp_rdy}, 5'b1);
        edges(OSCN - AMPN - 1);
        chk("R6 osc not yet", {3'b0, osc_rdy, tx_valid}, 5'b0);
        edges(1);
        chk("R6 osc ready", {4'b0, osc_rdy}, 5'b1);
        chk("R9 tx valid", {3'b0, tx_valid, lo_valid}, 5'b00010);

        // R9: path away from powered preamplifier -> no valid
        tx_sel = 1'b0; #1;
        chk("R9 path mismatch", {3'b0, tx_valid, lo_valid}, 5'b0);
        tx_sel = 1'b1;

        // R8: drop receive-off -> amp flag falls at once, osc stays
        edges(1);
        rx_off = 1'b0; #1;
        chk("R8 amp drop", {3'b0, osc_rdy, txamp_rdy}, 5'b00010);
        chk("R9 no tx valid", {3'b0, tx_valid, lo_valid}, 5'b0);
        tx_sel = 1'b0; #1;
        chk("R9 lo valid", {3'b0, tx_valid, lo_valid}, 5'b00001);
        edges(3);
        rx_off = 1'b1; tx_sel = 1'b1;
        edges(AMPN - 1);
        chk("R8 restart not yet", {4'b0, txamp_rdy}, 5'b0);
        edges(1);
        chk("R8 restart ready", {3'b0, txamp_rdy, tx_valid}, 5'b00011);

        // R8: short oscillator dropout restarts full interval
        osc_en = 1'b0; #1;
        chk("R8 osc drop", {3'b0, osc_rdy, txamp_rdy}, 5'b0);
        edges(1);
        osc_en = 1'b1;
        edges(OSCN - 1);
        chk("R8 osc restart not yet", {4'b0, osc_rdy}, 5'b0);
        edges(1);
        chk("R8 osc restart ready", {4'b0, osc_rdy}, 5'b1);

        // R10: reset while ready
        rst = 1'b1;
        edges(1);
        chk("R10 mid reset", {osc_rdy, txamp_rdy, tx_valid, lo_valid, 1'b0}, 5'b0);
        rst = 1'b0;
        edges(AMPN);
        chk("R10 after reset amp", {4'b0, txamp_rdy}, 5'b1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule